// File: doc/BRIEF.md
# PCI Read Initiator

This block is the read side of a PCI bus master. A requester on the chip hands it a start address, a length in 32-bit words, an access class (control structures such as descriptors and the init block, or transmit payload) and three mode bits: burst permission, a selector between the two long-read commands, and a request-hold option. The engine asks for the bus, waits for the grant and issues exactly one transaction. That transaction is one address phase followed by one or more data phases. Each word returned by the target is handed back with a one-cycle strobe.

The initiator adds no wait states of its own. Its ready line goes active in the first clock after the address phase, and the target sets the pace with its own ready line. If no target claims the cycle within a bounded number of clocks, the engine gives up the bus and reports an error pulse. The bus pins are modelled as separate in, out and enable signals in their active-low form. The pad logic combines them.

Top module: `pci_rd_master`

## Requirements
- R1: During and after reset the engine is idle: `bus_req_n`, `frame_n` and `irdy_n` are high, `ad_oe` and `ctl_oe` are low, `rd_valid`, `rd_done` and `rd_err` are low, and `req_ready` is high.
- R2: A request accepted while `req_ready` is high drives `bus_req_n` low on the next clock. `frame_n` goes low on the clock after `bus_gnt_n` is first sampled low.
- R3: The address phase lasts exactly one clock. During it `ad_oe` is high and `ad_o` carries the request address with bits [1:0] forced to 00, which marks linear burst order.
- R4: The command on `cbe_n` during the address phase is 4'b0110 when bursting is disabled or the class is control structures. For a transmit-payload burst it is 4'b1110 when `cfg_mult_cmd` is 0 and 4'b1100 when `cfg_mult_cmd` is 1.
- R5: `irdy_n` goes low on the clock right after the address phase, and `cbe_n` reads 4'b0000 (all lanes enabled) while `irdy_n` is low.
- R6: A data phase completes on a clock where `irdy_n` and `trdy_n` are both sampled low. On the next clock `rd_valid` is high for one cycle and `rd_data` holds the `ad_i` value sampled at that completing clock.
- R7: With `cfg_burst_en` set, the transaction has exactly `req_dwords` data phases. With it clear, it has exactly one, whatever the length.
- R8: `frame_n` rises on the clock after the next-to-last data phase completes, so that only `irdy_n` is low during the final phase. For a single phase, `frame_n` is already high when `irdy_n` first goes low.
- R9: With `cfg_hold_req` clear, `bus_req_n` rises on the same clock that `frame_n` falls. With it set, `bus_req_n` stays low until the clock after the final data phase completes.
- R10: After the final completion, `irdy_n` and `ctl_oe` release, `rd_done` pulses for one cycle and `req_ready` returns high. No second address phase follows in the same ownership.
- R11: If `devsel_n` is sampled high on each of the first `DEVSEL_TO` clocks after the address phase, the engine releases `frame_n`, `irdy_n`, `ctl_oe` and `bus_req_n`, pulses `rd_err` and returns no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a read; taken when `req_ready` is high |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | AD_W | Start byte address |
| req_dwords | input | CNT_W | Number of 32-bit words to read |
| req_txbuf | input | 1 | 1: transmit payload, 0: control structures |
| cfg_burst_en | input | 1 | Allow multi-phase reads |
| cfg_mult_cmd | input | 1 | Select the multiple-line read command for payload bursts |
| cfg_hold_req | input | 1 | Keep the bus request active until the last phase |
| rd_data | output | AD_W | Returned word |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_done | output | 1 | Transaction finished normally |
| rd_err | output | 1 | No target claimed the cycle |
| bus_req_n | output | 1 | Bus request, active low |
| bus_gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | Cycle frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Target claim, active low |
| ad_o | output | AD_W | Address/data bus out |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| ad_i | input | AD_W | Address/data bus in |
| cbe_n | output | 4 | Command / byte enables |
| ctl_oe | output | 1 | Drive enable for `frame_n`, `irdy_n`, `cbe_n` |

## Verification
The bench builds the engine with a 4-bit length field and the default claim window of five clocks. The narrow length keeps burst lengths small but still allows five-word bursts with the next-to-last FRAME release well inside the run. The default window lets the bench place a target claim on the very last permitted sample, and also withhold the claim entirely, so both sides of the abort boundary are exercised. Target wait states of zero, one and two clocks per phase are mixed with one-clock and delayed grants.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ADDR = 2'd2,
    ST_DATA = 2'd3
  } rd_state_t;

  localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
  localparam logic [3:0] BE_ALL_LANES    = 4'b0000;

endpackage

// File: rtl/rd_cmd_sel.sv
module rd_cmd_sel
  import pci_rd_pkg::*;
(
  input  logic       burst_en,
  input  logic       txbuf,
  input  logic       mult_cmd,
  output logic [3:0] cmd
);

  always_comb begin
    if (!burst_en || !txbuf)
      cmd = CMD_MEM_RD;
    else if (mult_cmd)
      cmd = CMD_MEM_RD_MULT;
    else
      cmd = CMD_MEM_RD_LINE;
  end

endmodule

// File: rtl/rd_beat_ctr.sv
module rd_beat_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] left,
  output logic             one_left,
  output logic             two_left
);

  always_ff @(posedge clk) begin
    if (rst)
      left <= '0;
    else if (load)
      left <= (load_val == '0) ? CNT_W'(1) : load_val;
    else if (dec)
      left <= left - CNT_W'(1);
  end

  assign one_left = (left == CNT_W'(1));
  assign two_left = (left == CNT_W'(2));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec |-> (left != '0)); // R7

endmodule

// File: rtl/rd_devsel_wdog.sv
module rd_devsel_wdog #(
  parameter int TO = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic devsel_n,
  output logic seen,
  output logic expire
);

  localparam int CW = $clog2(TO + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (en) begin
      if (!devsel_n)
        seen <= 1'b1;
      else if (!seen && cnt != CW'(TO))
        cnt <= cnt + CW'(1);
    end
  end

  assign expire = en && !seen && devsel_n && (cnt == CW'(TO - 1));

  AST_CLAIM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (en && seen && !clr) |=> seen); // R11

endmodule

// File: rtl/pci_rd_master.sv
module pci_rd_master
  import pci_rd_pkg::*;
#(
  parameter int AD_W      = 32,
  parameter int CNT_W     = 8,
  parameter int DEVSEL_TO = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AD_W-1:0]  req_addr,
  input  logic [CNT_W-1:0] req_dwords,
  input  logic             req_txbuf,
  input  logic             cfg_burst_en,
  input  logic             cfg_mult_cmd,
  input  logic             cfg_hold_req,
  output logic [AD_W-1:0]  rd_data,
  output logic             rd_valid,
  output logic             rd_done,
  output logic             rd_err,
  output logic             bus_req_n,
  input  logic             bus_gnt_n,
  output logic             frame_n,
  output logic             irdy_n,
  input  logic             trdy_n,
  input  logic             devsel_n,
  output logic [AD_W-1:0]  ad_o,
  output logic             ad_oe,
  input  logic [AD_W-1:0]  ad_i,
  output logic [3:0]       cbe_n,
  output logic             ctl_oe
);

  localparam logic [AD_W-1:0] ALIGN_MASK = ~AD_W'(3);

  rd_state_t        state;
  logic [AD_W-1:0]  lat_addr;
  logic             lat_txbuf, lat_burst, lat_mult, lat_hold;
  logic [3:0]       bus_cmd;
  logic [CNT_W-1:0] beats_left;
  logic             one_left, two_left;
  logic             xfer, claim_seen, expire;
  logic             accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign xfer      = (state == ST_DATA) && !irdy_n && !trdy_n;

  rd_cmd_sel u_cmd (
    .burst_en (lat_burst),
    .txbuf    (lat_txbuf),
    .mult_cmd (lat_mult),
    .cmd      (bus_cmd)
  );

  rd_beat_ctr #(.CNT_W(CNT_W)) u_beats (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (cfg_burst_en ? req_dwords : CNT_W'(1)),
    .dec      (xfer),
    .left     (beats_left),
    .one_left (one_left),
    .two_left (two_left)
  );

  rd_devsel_wdog #(.TO(DEVSEL_TO)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .clr      (state == ST_ADDR),
    .en       (state == ST_DATA),
    .devsel_n (devsel_n),
    .seen     (claim_seen),
    .expire   (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      lat_addr  <= '0;
      lat_txbuf <= 1'b0;
      lat_burst <= 1'b0;
      lat_mult  <= 1'b0;
      lat_hold  <= 1'b0;
      bus_req_n <= 1'b1;
      frame_n   <= 1'b1;
      irdy_n    <= 1'b1;
      ad_o      <= '0;
      ad_oe     <= 1'b0;
      cbe_n     <= 4'hF;
      ctl_oe    <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      rd_done   <= 1'b0;
      rd_err    <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
      rd_err   <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          lat_addr  <= req_addr;
          lat_txbuf <= req_txbuf;
          lat_burst <= cfg_burst_en;
          lat_mult  <= cfg_mult_cmd;
          lat_hold  <= cfg_hold_req;
          bus_req_n <= 1'b0;
          state     <= ST_REQ;
        end
        ST_REQ: if (!bus_gnt_n) begin
          frame_n <= 1'b0;
          ctl_oe  <= 1'b1;
          ad_oe   <= 1'b1;
          ad_o    <= lat_addr & ALIGN_MASK;
          cbe_n   <= bus_cmd;
          if (!lat_hold) bus_req_n <= 1'b1;
          state   <= ST_ADDR;
        end
        ST_ADDR: begin
          irdy_n  <= 1'b0;
          cbe_n   <= BE_ALL_LANES;
          ad_oe   <= 1'b0;
          frame_n <= one_left;
          state   <= ST_DATA;
        end
        ST_DATA: begin
          if (xfer) begin
            rd_valid <= 1'b1;
            rd_data  <= ad_i;
            if (one_left) begin
              irdy_n    <= 1'b1;
              ctl_oe    <= 1'b0;
              bus_req_n <= 1'b1;
              rd_done   <= 1'b1;
              state     <= ST_IDLE;
            end else if (two_left) begin
              frame_n <= 1'b1;
            end
          end else if (expire) begin
            frame_n   <= 1'b1;
            irdy_n    <= 1'b1;
            ctl_oe    <= 1'b0;
            bus_req_n <= 1'b1;
            rd_err    <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_n) |-> (ad_oe && ad_o[1:0] == 2'b00)); // R3
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_n) |-> (cbe_n == CMD_MEM_RD || cbe_n == CMD_MEM_RD_LINE
                        || cbe_n == CMD_MEM_RD_MULT)); // R4
  AST_IRDY_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_n) |=> !irdy_n); // R5
  AST_DATA_LANES: assert property (@(posedge clk) disable iff (rst)
    !irdy_n |-> (cbe_n == BE_ALL_LANES)); // R5
  AST_FINAL_PHASE: assert property (@(posedge clk) disable iff (rst)
    (!irdy_n && frame_n) |-> one_left); // R8
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    ($fell(frame_n) && !lat_hold) |-> bus_req_n); // R9
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (!rd_valid && claim_seen == 1'b0)); // R11

endmodule

// File: tb/pci_rd_master_test.sv
module pci_rd_master_test;

  localparam int AD_W  = 32;
  localparam int CNT_W = 4;
  localparam int TO    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [AD_W-1:0]  req_addr = '0;
  logic [CNT_W-1:0] req_dwords = '0;
  logic             req_txbuf = 1'b0, cfg_burst_en = 1'b0, cfg_mult_cmd = 1'b0, cfg_hold_req = 1'b0;
  logic [AD_W-1:0]  rd_data;
  logic             rd_valid, rd_done, rd_err;
  logic             bus_req_n, frame_n, irdy_n, ad_oe, ctl_oe;
  logic             bus_gnt_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1;
  logic [AD_W-1:0]  ad_o;
  logic [AD_W-1:0]  ad_i = '0;
  logic [3:0]       cbe_n;

  pci_rd_master #(.AD_W(AD_W), .CNT_W(CNT_W), .DEVSEL_TO(TO)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_dwords(req_dwords), .req_txbuf(req_txbuf),
    .cfg_burst_en(cfg_burst_en), .cfg_mult_cmd(cfg_mult_cmd), .cfg_hold_req(cfg_hold_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done), .rd_err(rd_err),
    .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
    .cbe_n(cbe_n), .ctl_oe(ctl_oe)
  );

  integer checks = 0, fails = 0, cyc = 0;
  bit     running = 1'b0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 wait grant, 2 address, 3 data
  integer     ph = 0, m_left = 0, wd = 0;
  bit         seen = 0;
  bit         m_req_n = 1, m_frame_n = 1, m_irdy_n = 1, m_oe = 0, m_ad_oe = 0;
  bit         m_vld = 0, m_done = 0, m_err = 0;
  logic [31:0] m_ad = '0, m_data = '0, b_addr = '0;
  logic [3:0]  m_cbe = 4'hF;
  bit         b_tx = 0, b_bu = 0, b_mu = 0, b_hold = 0;

  always @(posedge clk) begin
    cyc++;
    m_vld = 0; m_done = 0; m_err = 0;
    if (rst) begin
      ph = 0; m_req_n = 1; m_frame_n = 1; m_irdy_n = 1; m_oe = 0; m_ad_oe = 0;
    end else begin
      case (ph)
        0: if (req_valid) begin
          b_addr = req_addr; b_tx = req_txbuf; b_bu = cfg_burst_en;
          b_mu = cfg_mult_cmd; b_hold = cfg_hold_req;
          m_left = (!cfg_burst_en || req_dwords == 0) ? 1 : int'(req_dwords);
          m_req_n = 0; ph = 1;
        end
        1: if (!bus_gnt_n) begin
          m_frame_n = 0; m_oe = 1; m_ad_oe = 1;
          m_ad = {b_addr[31:2], 2'b00};
          m_cbe = (!b_bu || !b_tx) ? 4'b0110 : (b_mu ? 4'b1100 : 4'b1110);
          if (!b_hold) m_req_n = 1;
          ph = 2;
        end
        2: begin
          m_irdy_n = 0; m_cbe = 4'b0000; m_ad_oe = 0;
          m_frame_n = (m_left == 1);
          wd = 0; seen = 0; ph = 3;
        end
        default: begin
          if (!devsel_n) seen = 1;
          if (!trdy_n) begin
            m_vld = 1; m_data = ad_i; m_left--;
            if (m_left == 0) begin
              m_irdy_n = 1; m_oe = 0; m_req_n = 1; m_done = 1; ph = 0;
            end else if (m_left == 1) m_frame_n = 1;
          end else if (!seen) begin
            wd++;
            if (wd == TO) begin
              m_frame_n = 1; m_irdy_n = 1; m_oe = 0; m_req_n = 1; m_err = 1; ph = 0;
            end
          end
        end
      endcase
    end
  end

  integer dut_beats = 0, dut_errs = 0;
  always @(negedge clk) begin
    if (running && !rst) begin
      if (rd_valid) dut_beats++;
      if (rd_err) dut_errs++;
      chk(bus_req_n == m_req_n, "R2 R9 bus_req_n", 32'(bus_req_n), 32'(m_req_n));
      chk(frame_n == m_frame_n, "R8 frame_n", 32'(frame_n), 32'(m_frame_n));
      chk(irdy_n == m_irdy_n, "R5 irdy_n", 32'(irdy_n), 32'(m_irdy_n));
      chk(ad_oe == m_ad_oe, "R3 ad_oe", 32'(ad_oe), 32'(m_ad_oe));
      if (m_ad_oe) chk(ad_o == m_ad, "R3 ad_o", ad_o, m_ad);
      chk(ctl_oe == m_oe, "R10 ctl_oe", 32'(ctl_oe), 32'(m_oe));
      if (m_oe) chk(cbe_n == m_cbe, m_ad_oe ? "R4 cbe_n" : "R5 cbe_n", 32'(cbe_n), 32'(m_cbe));
      chk(rd_valid == m_vld, "R6 rd_valid", 32'(rd_valid), 32'(m_vld));
      if (m_vld) chk(rd_data == m_data, "R6 rd_data", rd_data, m_data);
      chk(rd_done == m_done, "R10 rd_done", 32'(rd_done), 32'(m_done));
      chk(rd_err == m_err, "R11 rd_err", 32'(rd_err), 32'(m_err));
      chk(req_ready == (ph == 0), "R10 req_ready", 32'(req_ready), 32'(ph == 0));
    end
  end

  task automatic run_txn(input logic [31:0] a, input integer n, input bit tx, input bit bu,
                         input bit mu, input bit hold, input integer gd, input integer dd,
                         input integer ws, input integer exp_beats, input integer exp_err);
    integer gc, k, tc, guard;
    bit dv;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_dwords = CNT_W'(n); req_txbuf = tx;
    cfg_burst_en = bu; cfg_mult_cmd = mu; cfg_hold_req = hold;
    @(negedge clk);
    req_valid = 0;
    dut_beats = 0; dut_errs = 0;
    gc = 0; k = 0; tc = 0; guard = 0;
    while (ph != 0 && guard < 300) begin
      if (m_vld) tc = 0;
      bus_gnt_n = !(ph == 1 && gc >= gd);
      if (ph == 1) gc++;
      dv = (ph == 3 && k >= dd);
      devsel_n = !dv;
      trdy_n = !(dv && tc >= ws);
      if (dv) tc++;
      if (ph == 3) k++;
      ad_i = 32'hC0DE_0000 | 32'(cyc);
      @(negedge clk);
      guard++;
    end
    bus_gnt_n = 1; devsel_n = 1; trdy_n = 1;
    if (guard >= 300) chk(0, "R10 transaction hung", 32'(guard), 32'd300);
    @(negedge clk);
    chk(dut_beats == exp_beats, "R7 data phase count", 32'(dut_beats), 32'(exp_beats));
    chk(dut_errs == exp_err, "R11 error pulses", 32'(dut_errs), 32'(exp_err));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 32'(cyc), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 idle state under reset
    chk(frame_n && irdy_n && bus_req_n, "R1 control lines high", {29'd0, frame_n, irdy_n, bus_req_n}, 32'd7);
    chk(!ad_oe && !ctl_oe, "R1 drivers off", {30'd0, ad_oe, ctl_oe}, 32'd0);
    chk(!rd_valid && !rd_done && !rd_err && req_ready, "R1 strobes and ready",
        {28'd0, rd_valid, rd_done, rd_err, req_ready}, 32'd1);
    rst = 0;
    running = 1;
    // payload, burst off: single phase, basic read command
    run_txn(32'h1000_0040, 4, 1, 0, 0, 0, 2, 0, 0, 1, 0);
    // control structures burst of 3, one wait state each, medium claim
    run_txn(32'h2000_0100, 3, 0, 1, 0, 0, 0, 1, 1, 3, 0);
    // payload burst of 4, line command, slow claim
    run_txn(32'h3000_0200, 4, 1, 1, 0, 0, 1, 2, 0, 4, 0);
    // payload burst of 2, multiple command, request held, two waits
    run_txn(32'h4000_0300, 2, 1, 1, 1, 1, 3, 0, 2, 2, 0);
    // burst of one with request held
    run_txn(32'h5000_0010, 1, 0, 1, 0, 1, 0, 0, 0, 1, 0);
    // claim on the last permitted sample
    run_txn(32'h6000_0020, 2, 1, 1, 1, 0, 0, TO - 1, 0, 2, 0);
    // no claim: abort
    run_txn(32'h7000_0030, 3, 1, 1, 0, 0, 0, 99, 0, 0, 1);
    // recovery, misaligned address, burst of 5
    run_txn(32'h8000_0047, 5, 1, 1, 0, 0, 1, 0, 1, 5, 0);
    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule